// File: doc/BRIEF.md
# PFC Supervisory Sequencer

This block sequences a power-factor-correction stage through its operating life. It decides when the line relay may close and when switching may run. It also produces the voltage-loop setpoint that the outer control loop regulates to. It watches the rectified-line RMS level, the measured bus voltage and three protection flags: overvoltage, overcurrent and overtemperature.

All decisions are taken on a single-cycle evaluation strobe, nominally 10 kHz. Between strobes the state and the setpoint hold still. Start-up needs a healthy line above an upper threshold. A lower threshold trips the stage back to waiting, so the line check has hysteresis.

During soft start the setpoint begins at the measured bus voltage and climbs by a programmable step toward the target. A protection trip is latched until an external clear arrives while no flag is active. The loop arithmetic itself is computed elsewhere.

Top module: `pfc_supervisor`

## Requirements
- R1: After reset the sequencer is in Wait (`phase` = 0) with `relay_on` = 0, `switch_on` = 0 and `vset` = 0. The encoding of `phase` is Wait=0, SoftStart=1, Run=2, Tripped=3.
- R2: State and setpoint change only on a cycle where `eval` is high. With `eval` low, every output holds.
- R3: In Wait, an `eval` with no protection flag and `line_rms` strictly above `START_LVL` (default 900) moves to SoftStart. When `line_rms` is equal to or below that level, or any flag is set, the sequencer stays in Wait.
- R4: On entry to SoftStart, `vset` is loaded with `vbus`, clamped to `vtarget`.
- R5: On each `eval` in SoftStart with `vbus` < `vtarget`, `vset` rises by `ramp_step` and saturates at `vtarget`.
- R6: An `eval` in SoftStart with `vbus` >= `vtarget` moves to Run. In Run, `vset` equals `vtarget`.
- R7: An `eval` in SoftStart or Run with any protection flag set moves to Tripped. This check takes priority over the line check.
- R8: An `eval` in SoftStart or Run with `line_rms` strictly below `STOP_LVL` (default 850) returns to Wait. At 850 or above, running continues.
- R9: Tripped persists until an `eval` sees `trip_clr` high with all flags clear; the sequencer then goes to Wait. A clear while a flag is active is ignored.
- R10: `relay_on` and `switch_on` are high only in SoftStart and Run. `vset` is 0 in Wait and Tripped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval | input | 1 | Evaluation strobe, one cycle per control tick |
| line_rms | input | VW | Line RMS level |
| vbus | input | VW | Measured bus voltage |
| vtarget | input | VW | Final bus setpoint |
| ramp_step | input | VW | Setpoint increment per tick during soft start |
| flag_ov | input | 1 | Overvoltage protection flag |
| flag_oc | input | 1 | Overcurrent protection flag |
| flag_ot | input | 1 | Overtemperature protection flag |
| trip_clr | input | 1 | Request to leave Tripped |
| relay_on | output | 1 | Line relay close command |
| switch_on | output | 1 | PWM enable |
| vset | output | VW | Voltage-loop setpoint |
| phase | output | 2 | Current sequencer state |

## Verification
Line levels are tried at the exact threshold values and one code on each side of them. This separates a strict from a non-strict compare and shows the hysteresis band.

The soft start is driven with a bus voltage below target, then one above target, then a step that overshoots. This tells seeding apart from stepping and clamping.

Faults are raised in SoftStart, in Run and in Wait, and clears are issued with a flag still active. This distinguishes the latched trip from the brownout path and the fault priority from the line priority.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_SOFT  = 2'd1,
    PH_RUN   = 2'd2,
    PH_TRIP  = 2'd3
  } pfc_phase_e;

  function automatic logic is_active(input pfc_phase_e p);
    return (p == PH_SOFT) || (p == PH_RUN);
  endfunction
endpackage

// File: rtl/pfc_line_monitor.sv
module pfc_line_monitor #(
  parameter int VW        = 12,
  parameter int START_LVL = 900,
  parameter int STOP_LVL  = 850
) (
  input  logic [VW-1:0] line_rms,
  output logic          line_good,
  output logic          line_low
);
  localparam logic [VW-1:0] StartC = VW'(START_LVL);
  localparam logic [VW-1:0] StopC  = VW'(STOP_LVL);

  // strict compares on both edges of the hysteresis band
  assign line_good = line_rms > StartC;
  assign line_low  = line_rms < StopC;

  initial begin
    assert (START_LVL > STOP_LVL) else $error("hysteresis band inverted");
  end
endmodule

// File: rtl/pfc_setpoint_ramp.sv
module pfc_setpoint_ramp #(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_clear,
  input  logic          sp_seed,
  input  logic          sp_lock,
  input  logic          sp_step,
  input  logic [VW-1:0] vbus,
  input  logic [VW-1:0] vtarget,
  input  logic [VW-1:0] ramp_step,
  output logic [VW-1:0] vset
);
  function automatic logic [VW-1:0] clamp_to(input logic [VW-1:0] v, input logic [VW-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [VW-1:0] step_sat(input logic [VW-1:0] cur, input logic [VW-1:0] inc,
                                            input logic [VW-1:0] lim);
    logic [VW:0] sum;
    sum = {1'b0, cur} + {1'b0, inc};
    return (sum >= {1'b0, lim}) ? lim : sum[VW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vset <= '0;
    else if (sp_clear) vset <= '0;
    else if (sp_seed)  vset <= clamp_to(vbus, vtarget);
    else if (sp_lock)  vset <= vtarget;
    else if (sp_step)  vset <= step_sat(vset, ramp_step, vtarget);
  end

  AST_STEP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_step && !sp_clear && !sp_seed && !sp_lock && vset <= vtarget) |=> (vset >= $past(vset))) else $error("setpoint fell"); // R5

  AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_step && !sp_clear && !sp_seed && !sp_lock) |=> (vset <= $past(vtarget))) else $error("setpoint over target"); // R5
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int VW        = 12,
  parameter int START_LVL = 900,
  parameter int STOP_LVL  = 850
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  logic [VW-1:0] line_rms,
  input  logic [VW-1:0] vbus,
  input  logic [VW-1:0] vtarget,
  input  logic [VW-1:0] ramp_step,
  input  logic          flag_ov,
  input  logic          flag_oc,
  input  logic          flag_ot,
  input  logic          trip_clr,
  output logic          relay_on,
  output logic          switch_on,
  output logic [VW-1:0] vset,
  output logic [1:0]    phase
);
  pfc_phase_e st, nxt;
  logic any_flag, line_good, line_low;
  logic go_start, go_trip, go_brown, go_run, go_clear;

  assign any_flag = flag_ov | flag_oc | flag_ot;

  pfc_line_monitor #(.VW(VW), .START_LVL(START_LVL), .STOP_LVL(STOP_LVL)) u_line (
    .line_rms (line_rms),
    .line_good(line_good),
    .line_low (line_low)
  );

  // named events, evaluated only on the strobe
  assign go_start = eval && (st == PH_WAIT) && !any_flag && line_good;
  assign go_trip  = eval && is_active(st) && any_flag;
  assign go_brown = eval && is_active(st) && !any_flag && line_low;
  assign go_run   = eval && (st == PH_SOFT) && !any_flag && !line_low && (vbus >= vtarget);
  assign go_clear = eval && (st == PH_TRIP) && trip_clr && !any_flag;

  always_comb begin
    nxt = st;
    if (go_start)      nxt = PH_SOFT;
    else if (go_trip)  nxt = PH_TRIP;
    else if (go_brown) nxt = PH_WAIT;
    else if (go_run)   nxt = PH_RUN;
    else if (go_clear) nxt = PH_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PH_WAIT;
    else        st <= nxt;
  end

  pfc_setpoint_ramp #(.VW(VW)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp_clear (go_trip || go_brown || go_clear),
    .sp_seed  (go_start),
    .sp_lock  (eval && (nxt == PH_RUN)),
    .sp_step  (eval && (st == PH_SOFT) && (nxt == PH_SOFT)),
    .vbus     (vbus),
    .vtarget  (vtarget),
    .ramp_step(ramp_step),
    .vset     (vset)
  );

  assign relay_on  = is_active(st);
  assign switch_on = is_active(st);
  assign phase     = st;

  AST_HOLD_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> ($stable(phase) && $stable(vset))) else $error("moved without strobe"); // R2

  AST_START_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> (phase == 2'd1 && vset == (($past(vbus) > $past(vtarget)) ? $past(vtarget) : $past(vbus)))) else $error("bad seed"); // R4

  AST_TRIP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && any_flag && (phase == 2'd1 || phase == 2'd2)) |=> (phase == 2'd3 && !switch_on)) else $error("no trip"); // R7

  AST_BROWNOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !any_flag && line_low && (phase == 2'd1 || phase == 2'd2)) |=> (phase == 2'd0 && !relay_on)) else $error("no brownout exit"); // R8

  AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && !(eval && trip_clr && !any_flag)) |=> (phase == 2'd3)) else $error("trip released"); // R9

  AST_RUN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && phase == 2'd2 && !any_flag && !line_low) |=> (vset == $past(vtarget))) else $error("run setpoint"); // R6
endmodule

// File: tb/test_pfc_supervisor.sv
module test_pfc_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 12;

  logic clk = 0, rst_n = 0, eval = 0;
  logic [VW-1:0] line_rms = 0, vbus = 0, vtarget = 0, ramp_step = 0;
  logic flag_ov = 0, flag_oc = 0, flag_ot = 0, trip_clr = 0;
  logic relay_on, switch_on;
  logic [VW-1:0] vset;
  logic [1:0] phase;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_supervisor i_pfc_supervisor (
    .clk(clk), .rst_n(rst_n), .eval(eval), .line_rms(line_rms), .vbus(vbus),
    .vtarget(vtarget), .ramp_step(ramp_step), .flag_ov(flag_ov), .flag_oc(flag_oc),
    .flag_ot(flag_ot), .trip_clr(trip_clr), .relay_on(relay_on), .switch_on(switch_on),
    .vset(vset), .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int ph, input int sp);
    chk(req, phase, ph);
    chk(req, vset, sp);
    chk(req, relay_on, (ph == 1 || ph == 2) ? 1 : 0);
    chk(req, switch_on, (ph == 1 || ph == 2) ? 1 : 0);
  endtask

  // one strobe cycle; outputs read at the following falling edge
  task automatic tick();
    @(negedge clk) eval = 1;
    @(negedge clk) eval = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; eval = 0; flag_ov = 0; flag_oc = 0; flag_ot = 0; trip_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1 reset", 0, 0);
  endtask

  task automatic t_no_eval();
    do_reset();
    line_rms = 1000; vbus = 300; vtarget = 600;
    repeat (4) @(negedge clk);
    chk_state("R2 no strobe", 0, 0);
  endtask

  task automatic t_start_gate();
    do_reset();
    vbus = 300; vtarget = 600; ramp_step = 20;
    line_rms = 900; tick();
    chk_state("R3 at start level", 0, 0);
    line_rms = 901; flag_ot = 1; tick();
    chk_state("R3 flag blocks start", 0, 0);
    flag_ot = 0; tick();
    chk_state("R3 start", 1, 300);
  endtask

  task automatic t_ramp();
    do_reset();
    line_rms = 950; vbus = 400; vtarget = 500; ramp_step = 30;
    tick();
    chk_state("R4 seed", 1, 400);
    tick(); chk_state("R5 step1", 1, 430);
    tick(); chk_state("R5 step2", 1, 460);
    tick(); chk_state("R5 step3", 1, 490);
    tick(); chk_state("R5 clamp", 1, 500);
    vbus = 500; tick();
    chk_state("R6 enter run", 2, 500);
    vtarget = 520; tick();
    chk_state("R6 run tracks", 2, 520);
  endtask

  task automatic t_seed_clamp();
    do_reset();
    line_rms = 950; vbus = 700; vtarget = 600; ramp_step = 5;
    tick();
    chk_state("R4 seed clamp", 1, 600);
    tick();
    chk_state("R6 run from high bus", 2, 600);
  endtask

  task automatic t_brownout();
    do_reset();
    line_rms = 950; vbus = 600; vtarget = 600; ramp_step = 10;
    tick(); tick();
    chk_state("R6 run", 2, 600);
    line_rms = 850; tick();
    chk_state("R8 at stop level", 2, 600);
    line_rms = 849; tick();
    chk_state("R8 brownout", 0, 0);
    line_rms = 880; tick();
    chk_state("R3 inside band", 0, 0);
    line_rms = 950; vbus = 300; tick();
    line_rms = 800; tick();
    chk_state("R8 brownout in soft start", 0, 0);
  endtask

  task automatic t_trip();
    do_reset();
    line_rms = 950; vbus = 300; vtarget = 600; ramp_step = 10;
    tick();
    line_rms = 800; flag_oc = 1; tick();
    chk_state("R7 trip beats brownout", 3, 0);
    flag_oc = 0; line_rms = 950; tick();
    chk_state("R9 latched", 3, 0);
    flag_ov = 1; trip_clr = 1; tick();
    chk_state("R9 clear ignored with flag", 3, 0);
    flag_ov = 0; tick();
    chk_state("R9 cleared", 0, 0);
    trip_clr = 0; vbus = 600; tick(); tick();
    chk_state("R6 run again", 2, 600);
    flag_ot = 1; tick();
    chk_state("R7 trip in run", 3, 0);
    chk("R10 relay open in trip", relay_on, 0);
  endtask

  initial begin
    t_reset();
    t_no_eval();
    t_start_gate();
    t_ramp();
    t_seed_clamp();
    t_brownout();
    t_trip();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule